// File: doc/BRIEF.md
# Mailbox Interrupt Flag Logic

This block produces the cross-port interrupt flags for a two-port memory in which the two highest word addresses act as mailboxes. The top address belongs to the right port and the address just below it belongs to the left port. When one port writes into the other port's mailbox, the owner's interrupt is raised. The interrupt stays raised until the owner reads its own mailbox.

The block only observes the access controls of each port: select, write/read direction, output enable, address and an arbitration busy input. The message itself lives in the memory array and never reaches this logic. A port that is being held off by arbitration can neither raise the other side's interrupt nor clear its own. All decisions are taken on the rising clock edge, and each interrupt output changes one cycle after the access that caused it.

Top module: `mbox_irq`

## Requirements
- R1: While `rst_n` is low, both `lp_irq_n` and `rp_irq_n` are high (inactive). The interrupt outputs are active low.
- R2: A left-port write (`lp_sel`=1, `lp_wr`=1) to address all-ones with `lp_busy`=0 drives `rp_irq_n` low after the next rising clock edge.
- R3: A right-port write to address all-ones minus one with `rp_busy`=0 drives `lp_irq_n` low after the next rising clock edge.
- R4: An owner read (select=1, `*_wr`=0, `*_oe`=1, busy=0) of its own mailbox (right: all-ones, left: all-ones minus one) returns that owner's interrupt output high after the next rising edge.
- R5: A read of the other port's mailbox leaves both interrupt outputs unchanged.
- R6: A write into the other port's mailbox while the writer's busy input is 1 does not raise the other port's interrupt.
- R7: An owner read of its own mailbox while the owner's busy input is 1 does not clear its interrupt.
- R8: If the set and the clear of the same interrupt fall into the same cycle, the interrupt ends up raised.
- R9: Accesses with select low, reads with output enable low, writes into a port's own mailbox and accesses to any address below the two mailboxes change no interrupt; the written data has no part in the decision.
- R10: With no set or clear condition, each interrupt output keeps its value from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| lp_sel | input | 1 | Left port memory select, active high |
| lp_wr | input | 1 | Left port direction: 1 write, 0 read |
| lp_oe | input | 1 | Left port output enable, active high |
| lp_addr | input | AW | Left port word address |
| lp_busy | input | 1 | Left port held off by arbitration, active high |
| rp_sel | input | 1 | Right port memory select, active high |
| rp_wr | input | 1 | Right port direction: 1 write, 0 read |
| rp_oe | input | 1 | Right port output enable, active high |
| rp_addr | input | AW | Right port word address |
| rp_busy | input | 1 | Right port held off by arbitration, active high |
| lp_irq_n | output | 1 | Left port interrupt, active low |
| rp_irq_n | output | 1 | Right port interrupt, active low |

## Verification
The assertions assume that every control and address input is settled and known around each rising edge, and that busy is already resolved by the arbiter in the cycle of the access it qualifies. The bench honours this by changing all inputs on the falling edge and sampling the interrupt outputs on the following falling edge, so each access occupies exactly one clock cycle. The stimulus walks a chained sequence in which each step starts from the flag state the previous step left, which places the busy-gated, set-versus-clear and ignored-access cases against both a raised and a cleared interrupt.

// File: rtl/mbox_irq.sv
module mbox_irq #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lp_sel,
  input  logic          lp_wr,
  input  logic          lp_oe,
  input  logic [AW-1:0] lp_addr,
  input  logic          lp_busy,
  input  logic          rp_sel,
  input  logic          rp_wr,
  input  logic          rp_oe,
  input  logic [AW-1:0] rp_addr,
  input  logic          rp_busy,
  output logic          lp_irq_n,
  output logic          rp_irq_n
);

  localparam logic [AW-1:0] RBOX = '1;
  localparam logic [AW-1:0] LBOX = RBOX - 1'b1;

  logic lp_wr_ok, lp_rd_ok, rp_wr_ok, rp_rd_ok;
  logic set_l, clr_l, set_r, clr_r;
  logic irq_l, irq_r;

  assign lp_wr_ok = lp_sel & lp_wr & ~lp_busy;
  assign lp_rd_ok = lp_sel & ~lp_wr & lp_oe & ~lp_busy;
  assign rp_wr_ok = rp_sel & rp_wr & ~rp_busy;
  assign rp_rd_ok = rp_sel & ~rp_wr & rp_oe & ~rp_busy;

  assign set_r = lp_wr_ok & (lp_addr == RBOX);
  assign clr_r = rp_rd_ok & (rp_addr == RBOX);
  assign set_l = rp_wr_ok & (rp_addr == LBOX);
  assign clr_l = lp_rd_ok & (lp_addr == LBOX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_l <= 1'b0;
      irq_r <= 1'b0;
    end else begin
      irq_l <= set_l | (irq_l & ~clr_l);
      irq_r <= set_r | (irq_r & ~clr_r);
    end
  end

  assign lp_irq_n = ~irq_l;
  assign rp_irq_n = ~irq_r;

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |-> (lp_irq_n && rp_irq_n));

  a_r2_left_sets_right: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_sel && lp_wr && !lp_busy && lp_addr == RBOX) |=> !rp_irq_n);

  a_r3_right_sets_left: assert property (@(posedge clk) disable iff (!rst_n)
    (rp_sel && rp_wr && !rp_busy && rp_addr == LBOX) |=> !lp_irq_n);

  a_r4_right_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rp_sel && !rp_wr && rp_oe && !rp_busy && rp_addr == RBOX &&
     !(lp_sel && lp_wr && !lp_busy && lp_addr == RBOX)) |=> rp_irq_n);

  a_r4_left_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_sel && !lp_wr && lp_oe && !lp_busy && lp_addr == LBOX &&
     !(rp_sel && rp_wr && !rp_busy && rp_addr == LBOX)) |=> lp_irq_n);

  a_r7_busy_keeps_right: assert property (@(posedge clk) disable iff (!rst_n)
    (!rp_irq_n && rp_busy) |=> !rp_irq_n);

  a_r7_busy_keeps_left: assert property (@(posedge clk) disable iff (!rst_n)
    (!lp_irq_n && lp_busy) |=> !lp_irq_n);

  a_r6_busy_no_set_right: assert property (@(posedge clk) disable iff (!rst_n)
    (rp_irq_n && lp_busy) |=> rp_irq_n);

  a_r6_busy_no_set_left: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_irq_n && rp_busy) |=> lp_irq_n);

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!lp_sel && !rp_sel) |=> ($stable(lp_irq_n) && $stable(rp_irq_n)));

endmodule

// File: tb/mbox_irq_test.sv
module mbox_irq_test;
  localparam int AW = 12;
  localparam int NV = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lp_sel = 0, lp_wr = 0, lp_oe = 0, lp_busy = 0;
  logic rp_sel = 0, rp_wr = 0, rp_oe = 0, rp_busy = 0;
  logic [AW-1:0] lp_addr = '0, rp_addr = '0;
  logic lp_irq_n, rp_irq_n;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mbox_irq #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .lp_sel(lp_sel), .lp_wr(lp_wr), .lp_oe(lp_oe), .lp_addr(lp_addr), .lp_busy(lp_busy),
    .rp_sel(rp_sel), .rp_wr(rp_wr), .rp_oe(rp_oe), .rp_addr(rp_addr), .rp_busy(rp_busy),
    .lp_irq_n(lp_irq_n), .rp_irq_n(rp_irq_n)
  );

  // entry: {lsel,lwr,loe,lcode[1:0],lbusy, rsel,rwr,roe,rcode[1:0],rbusy, exp_l_n,exp_r_n}
  // address code: 0 = ordinary word 5, 1 = all-ones minus one, 2 = all-ones
  localparam logic [13:0] VEC [NV] = '{
    {6'b110_10_0, 6'b000_00_0, 2'b10},
    {6'b101_10_0, 6'b000_00_0, 2'b10},
    {6'b000_00_0, 6'b110_10_0, 2'b10},
    {6'b000_00_0, 6'b101_10_1, 2'b10},
    {6'b000_00_0, 6'b100_10_0, 2'b10},
    {6'b000_00_0, 6'b101_10_0, 2'b11},
    {6'b000_00_0, 6'b110_01_1, 2'b11},
    {6'b000_00_0, 6'b110_01_0, 2'b01},
    {6'b000_00_0, 6'b101_01_0, 2'b01},
    {6'b110_00_0, 6'b000_00_0, 2'b01},
    {6'b000_00_0, 6'b000_00_0, 2'b01},
    {6'b101_01_0, 6'b000_00_0, 2'b11},
    {6'b110_10_0, 6'b101_10_0, 2'b10},
    {6'b110_01_0, 6'b110_00_0, 2'b10},
    {6'b010_10_0, 6'b101_10_0, 2'b11},
    {6'b010_10_0, 6'b000_00_0, 2'b11}
  };
  string tags [NV] = '{"R2", "R5", "R9", "R7", "R9", "R4", "R6", "R3",
                       "R5", "R9", "R10", "R4", "R8", "R9", "R4", "R9"};

  function automatic logic [AW-1:0] addr_of(input logic [1:0] c);
    case (c)
      2'd1:    return {{(AW-1){1'b1}}, 1'b0};
      2'd2:    return '1;
      default: return AW'(5);
    endcase
  endfunction

  task automatic check(input logic el, input logic er, input string tag);
    checks++;
    if (lp_irq_n !== el || rp_irq_n !== er) begin
      fails++;
      $display("FAIL %s: lp_irq_n/rp_irq_n got %b%b expected %b%b", tag, lp_irq_n, rp_irq_n, el, er);
    end
  endtask

  task automatic drive(input logic [11:0] v);
    {lp_sel, lp_wr, lp_oe} = v[11:9];
    lp_addr = addr_of(v[8:7]);
    lp_busy = v[6];
    {rp_sel, rp_wr, rp_oe} = v[5:3];
    rp_addr = addr_of(v[2:1]);
    rp_busy = v[0];
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: cycles got %0d expected below 5000", cycles);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1'b1, 1'b1, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    check(1'b1, 1'b1, "R1");

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][13:2]);
      @(negedge clk);
      check(VEC[i][1], VEC[i][0], tags[i]);
    end

    // R8 on the left flag: right sets while left clears
    drive({6'b101_01_0, 6'b110_01_0});
    @(negedge clk);
    check(1'b0, 1'b1, "R8");

    // R10: flag persists over several idle cycles
    drive(12'b0);
    repeat (4) @(negedge clk);
    check(1'b0, 1'b1, "R10");

    // R1: reset mid-run drops both raised flags
    drive({6'b110_10_0, 6'b000_00_0});
    @(negedge clk);
    check(1'b0, 1'b0, "R2");
    drive(12'b0);
    rst_n = 1'b0;
    #1;
    check(1'b1, 1'b1, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(1'b1, 1'b1, "R1");

    summary();
  end
endmodule